// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a serial EEPROM that answers as a target on a two-wire bus. It recognises START and STOP conditions. It answers only to a device select byte that matches its fixed prefix and two strap inputs, so four copies can share one bus. A write transaction loads a word address and then stores data bytes into an internal byte array. A read transaction streams bytes from the current address.

The bus lines are oversampled on the system clock. Incoming bits are taken on rising SCL. The block changes its own SDA pull-down only while SCL is low, and it never drives the line high. A write-protect input blocks every store to the array. The block still acknowledges the bytes and still serves reads. Writes take effect at once; there is no programming delay.

Top module: `serial_eeprom`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new transaction from any state, including in the middle of a byte. After a STOP (SDA rising while SCL is high) the block releases SDA (sdaOe = 0).
- R2: The first byte after START is the device select byte, sent MSB first as {1010, 0, strapIn[1], strapIn[0], R/W}, where R/W = 1 means read. The block pulls SDA low in the acknowledge slot only when bits 7:1 match. Otherwise it leaves SDA released until the next START.
- R3: sdaOe is 0 after reset. SDA is only ever pulled low or released, and the block changes sdaOe only while SCL is low.
- R4: A write transaction sends the word address high byte, then the low byte. Bits 6:0 of the high byte become address bits 14:8, and bit 7 of the high byte is ignored. The block acknowledges both address bytes.
- R5: Each data byte of a write is stored at the current address and acknowledged. The low 6 address bits then increment and wrap inside the 64-byte page, and address bits 14:6 do not change.
- R6: While wpIn is 1, data bytes are still acknowledged but the array is left unchanged. Reads are not affected.
- R7: A read returns the byte at the current address, then increments the full 15-bit address, so 0x7FFF is followed by 0x0000. A read that starts without an address phase continues from the address left by the previous access.
- R8: A master NACK after a read byte ends the read. SDA stays released on later SCL pulses until the next START.
- R9: A repeated START followed by a read select, sent after the two address bytes, reads from the address just loaded.
- R10: With default parameters the array holds 2048 bytes, indexed by address bits 10:0. Address bits 14:11 alias onto the same storage, and widening the storage parameter gives the full 32768-byte array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| strapIn | input | 2 | Device select strap bits, low bits of the select |
| wpIn | input | 1 | 1 blocks all stores to the array |

## Verification
The assertions watch, on every cycle, that the SDA pull-down never moves while SCL is high and that a released state holds whenever the target is idle. They also check that each store lands in the array or, under write protect, leaves it untouched, that page writes keep the address bits above the page offset, and that each read byte advances the address by one. Only the bench's scenarios can show the behaviour seen from the bus. These include the acknowledge decisions for matching and non-matching selects, the order of bytes across a page wrap and across the top of the address space, the alias of high address bits onto the default storage, the silent bus after a NACK, and the restart of decoding when a START arrives in the middle of a byte.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

  typedef enum logic [2:0] {
    stIdle,
    stDev,
    stHi,
    stLo,
    stWr,
    stRd
  } eeState_t;

  // Single-cycle requests from control to datapath
  typedef struct packed {
    logic       loadHi;
    logic       loadLo;
    logic       writeByte;
    logic       nextRead;
    logic [7:0] data;
  } eeStrobe_t;

endpackage

// File: rtl/serial_eeprom_ctrl.sv
module serial_eeprom_ctrl
  import serial_eeprom_pkg::*;
#(
  parameter logic [4:0] DEV_PREFIX = 5'b10100,
  parameter int         SYNC_LEN   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strapIn,
  input  logic [7:0] rdByte,
  output eeStrobe_t  strb,
  output logic       sdaLow
);

  localparam int PIPE = SYNC_LEN + 1;

  logic [PIPE-1:0] sclSync, sdaSync;
  logic sclS, sclPrev, sdaS, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;

  eeState_t   st;
  logic [3:0] cnt;
  logic       inAck;
  logic [7:0] shIn;
  logic [7:0] rdSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[PIPE-2:0], sclIn};
      sdaSync <= {sdaSync[PIPE-2:0], sdaIn};
    end
  end

  assign sclS      = sclSync[PIPE-2];
  assign sclPrev   = sclSync[PIPE-1];
  assign sdaS      = sdaSync[PIPE-2];
  assign sdaPrev   = sdaSync[PIPE-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= stIdle;
      cnt    <= '0;
      inAck  <= 1'b0;
      shIn   <= '0;
      rdSh   <= '0;
      sdaLow <= 1'b0;
      strb   <= '0;
    end else begin
      strb <= '0;
      if (startCond) begin
        st     <= stDev;
        cnt    <= '0;
        inAck  <= 1'b0;
        sdaLow <= 1'b0;
      end else if (stopCond) begin
        st     <= stIdle;
        cnt    <= '0;
        inAck  <= 1'b0;
        sdaLow <= 1'b0;
      end else if (st != stIdle) begin
        if (sclRise) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
            if (st != stRd) shIn <= {shIn[6:0], sdaS};
          end else begin
            cnt <= '0;
            // master acknowledge slot of a read byte
            if (st == stRd && sdaS) st <= stIdle;
          end
        end else if (sclFall) begin
          if (cnt == 4'd8 && !inAck) begin
            inAck <= 1'b1;
            unique case (st)
              stDev: begin
                if (shIn[7:1] == {DEV_PREFIX, strapIn}) begin
                  sdaLow <= 1'b1;
                  st     <= shIn[0] ? stRd : stHi;
                end else begin
                  sdaLow <= 1'b0;
                  st     <= stIdle;
                end
              end
              stHi: begin
                sdaLow      <= 1'b1;
                strb.loadHi <= 1'b1;
                strb.data   <= shIn;
                st          <= stLo;
              end
              stLo: begin
                sdaLow      <= 1'b1;
                strb.loadLo <= 1'b1;
                strb.data   <= shIn;
                st          <= stWr;
              end
              stWr: begin
                sdaLow         <= 1'b1;
                strb.writeByte <= 1'b1;
                strb.data      <= shIn;
              end
              default: sdaLow <= 1'b0;
            endcase
          end else if (cnt == 4'd0 && inAck) begin
            inAck <= 1'b0;
            if (st == stRd) begin
              sdaLow        <= ~rdByte[7];
              rdSh          <= {rdByte[6:0], 1'b0};
              strb.nextRead <= 1'b1;
            end else begin
              sdaLow <= 1'b0;
            end
          end else if (st == stRd && cnt != 4'd0 && cnt < 4'd8) begin
            sdaLow <= ~rdSh[7];
            rdSh   <= {rdSh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R3: the pull-down only moves while SCL is low
  assert_scl_high_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaLow));

  // R2: an idle target never pulls the line
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st == stIdle) |-> !sdaLow);

endmodule

// File: rtl/serial_eeprom_dp.sv
module serial_eeprom_dp
  import serial_eeprom_pkg::*;
#(
  parameter int ADDR_BITS  = 15,
  parameter int STORE_BITS = 11,
  parameter int PAGE_BITS  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  eeStrobe_t  strb,
  input  logic       wpIn,
  output logic [7:0] rdByte
);

  localparam int HI_BITS = ADDR_BITS - 8;
  localparam int DEPTH   = 1 << STORE_BITS;

  logic [7:0]           mem [DEPTH];
  logic [ADDR_BITS-1:0] ptr;
  logic [STORE_BITS-1:0] idx;

  assign idx    = ptr[STORE_BITS-1:0];
  assign rdByte = mem[idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.loadHi) begin
      ptr[ADDR_BITS-1:8] <= strb.data[HI_BITS-1:0];
    end else if (strb.loadLo) begin
      ptr[7:0] <= strb.data;
    end else if (strb.writeByte) begin
      ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
    end else if (strb.nextRead) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeByte && !wpIn) mem[idx] <= strb.data;
  end

  // R5: page writes keep the bits above the page offset
  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> ptr[ADDR_BITS-1:PAGE_BITS] == $past(ptr[ADDR_BITS-1:PAGE_BITS]));

  // R5: an unprotected store lands in the array
  assert_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && !wpIn) |=> mem[$past(idx)] == $past(strb.data));

  // R6: a protected store leaves the array untouched
  assert_wp_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && wpIn) |=> mem[$past(idx)] == $past(rdByte));

  // R7: each read byte advances the full address by one
  assert_read_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.nextRead |=> ptr == $past(ptr) + 1'b1);

endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
  import serial_eeprom_pkg::*;
#(
  parameter int ADDR_BITS  = 15,
  parameter int STORE_BITS = 11,
  parameter int PAGE_BITS  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [1:0] strapIn,
  input  logic       wpIn
);

  eeStrobe_t  strb;
  logic [7:0] rdByte;

  serial_eeprom_ctrl #(
    .DEV_PREFIX(5'b10100),
    .SYNC_LEN  (2)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .strapIn(strapIn),
    .rdByte (rdByte),
    .strb   (strb),
    .sdaLow (sdaOe)
  );

  serial_eeprom_dp #(
    .ADDR_BITS (ADDR_BITS),
    .STORE_BITS(STORE_BITS),
    .PAGE_BITS (PAGE_BITS)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wpIn  (wpIn),
    .rdByte(rdByte)
  );

endmodule

// File: tb/serial_eeprom_tb.sv
module serial_eeprom_tb;

  localparam int Q      = 6;
  localparam int STORE  = 2048;
  localparam int AMASK  = 32'h7FFF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       sdaDrv = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       wp = 1'b0;
  logic       sdaOe;
  logic       sdaLine;

  int checks = 0;
  int errors = 0;
  int benchPtr = 0;
  logic [7:0] model [STORE];
  bit         known [STORE];

  assign sdaLine = sdaDrv & ~sdaOe;

  serial_eeprom u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclLine),
    .sdaIn  (sdaLine),
    .sdaOe  (sdaOe),
    .strapIn(strap),
    .wpIn   (wp)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] devByte(input logic [1:0] s, input bit rd);
    return {5'b10100, s, rd};
  endfunction

  function automatic int pageStep(input int a);
    return (a & ~63) | ((a + 1) & 63);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclLine = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      sclLine = 1'b1; waitQ();
      sclLine = 1'b0; waitQ();
    end
    sdaDrv = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    acked = !sdaLine;
    waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclLine = 1'b1; waitQ();
      b[i] = sdaLine;
      sclLine = 1'b0; waitQ();
    end
    sdaDrv = masterAck ? 1'b0 : 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    sclLine = 1'b0; waitQ();
    sdaDrv = 1'b1;
  endtask

  task automatic writeSeq(input int addr, input int n, input string req);
    bit a;
    logic [7:0] d;
    int p;
    busStart();
    sendByte(devByte(strap, 1'b0), a); check(a, "R2 select ack", a, 1);
    sendByte(8'((addr >> 8) & 255), a); check(a, "R4 high ack", a, 1);
    sendByte(8'(addr & 255), a);        check(a, "R4 low ack", a, 1);
    p = addr & AMASK;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, a);
      check(a, req, a, 1);
      if (!wp) begin
        model[p % STORE] = d;
        known[p % STORE] = 1'b1;
      end
      p = pageStep(p);
    end
    busStop();
    check(sdaOe == 1'b0, "R1 released after stop", sdaOe, 0);
    benchPtr = p;
  endtask

  task automatic readBody(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      if (known[benchPtr % STORE])
        check(b == model[benchPtr % STORE], req, b, model[benchPtr % STORE]);
      benchPtr = (benchPtr + 1) & AMASK;
    end
  endtask

  task automatic readRandom(input int addr, input int n, input string req);
    bit a;
    busStart();
    sendByte(devByte(strap, 1'b0), a); check(a, "R9 select ack", a, 1);
    sendByte(8'((addr >> 8) & 255), a); check(a, "R9 high ack", a, 1);
    sendByte(8'(addr & 255), a);        check(a, "R9 low ack", a, 1);
    busStart();
    sendByte(devByte(strap, 1'b1), a); check(a, "R9 read select ack", a, 1);
    benchPtr = addr & AMASK;
    readBody(n, req);
    busStop();
  endtask

  task automatic readCurrent(input int n, input string req);
    bit a;
    busStart();
    sendByte(devByte(strap, 1'b1), a); check(a, "R7 read select ack", a, 1);
    readBody(n, req);
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    int unsigned seedVal;
    int addr, n;
    logic [7:0] b;
    seedVal = $urandom(32'd4242);
    for (int i = 0; i < STORE; i++) known[i] = 1'b0;
    repeat (4) @(negedge clk);
    check(sdaOe == 1'b0, "R3 reset released", sdaOe, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(sdaOe == 1'b0, "R3 idle after reset", sdaOe, 0);

    // R2: select for other straps is ignored
    busStart();
    sendByte(devByte(2'b10, 1'b0), a);
    check(!a, "R2 foreign select nack", a, 0);
    sendByte(8'h00, a);
    check(!a, "R2 silent until start", a, 0);
    busStop();

    // R1: START in the middle of a byte restarts decoding
    busStart();
    for (int i = 0; i < 4; i++) begin
      sdaDrv = i[0]; waitQ();
      sclLine = 1'b1; waitQ();
      sclLine = 1'b0; waitQ();
    end
    busStart();
    sendByte(devByte(strap, 1'b0), a);
    check(a, "R1 restart select ack", a, 1);
    busStop();

    // R3/R4/R5/R9: single byte write, random read back
    writeSeq(32'h0123, 1, "R5 data ack");
    readRandom(32'h0123, 1, "R9 random read");

    // R5: page wrap; neighbours of the next page untouched
    writeSeq(32'h00C0, 2, "R5 data ack");
    writeSeq(32'h00BE, 4, "R5 page data ack");
    readRandom(32'h00BE, 4, "R7 cross-page read");
    readRandom(32'h0080, 2, "R5 page wrap stored");

    // R4: bit 7 of the high byte ignored
    writeSeq(32'h8110, 1, "R4 data ack");
    readRandom(32'h0110, 1, "R4 high bit ignored");

    // R7: address wraps at the top; current-address read continues
    writeSeq(32'h0000, 2, "R7 data ack");
    writeSeq(32'h7FFF, 1, "R7 data ack");
    readRandom(32'h7FFF, 2, "R7 top wrap");
    readCurrent(1, "R7 current address");

    // R10: high address bits alias onto default storage
    writeSeq(32'h0805, 1, "R10 data ack");
    readRandom(32'h0005, 1, "R10 alias");

    // R6: write protect
    wp = 1'b1;
    writeSeq(32'h0123, 3, "R6 protected ack");
    readRandom(32'h0123, 3, "R6 array unchanged");
    wp = 1'b0;

    // R8: NACK ends the read, bus stays silent
    busStart();
    sendByte(devByte(strap, 1'b1), a);
    check(a, "R8 select ack", a, 1);
    recvByte(1'b0, b);
    sdaDrv = 1'b1;
    for (int i = 0; i < 9; i++) begin
      waitQ();
      sclLine = 1'b1; waitQ();
      check(sdaOe == 1'b0, "R8 silent after nack", sdaOe, 0);
      sclLine = 1'b0; waitQ();
    end
    busStop();

    // R2: strap change moves the select
    strap = 2'b10;
    writeSeq(32'h0200, 2, "R2 strap data ack");
    readRandom(32'h0200, 2, "R2 strap read");
    strap = 2'b01;

    // random page writes and reads
    for (int t = 0; t < 10; t++) begin
      addr = int'($urandom & 32'h7FFF);
      n = 1 + int'($urandom % 8);
      writeSeq(addr, n, "R5 random data ack");
      readRandom(addr, n, "R7 random read");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule